// File: doc/BRIEF.md
# Multiplexed Address/Data Local-Bus Master

This block is a local-bus master that carries out internal read and write requests to a narrow, byte-wide external peripheral. The peripheral sits on a shared bus that carries the address first and the data after it. Each byte is its own access, with its own address phase. During the address phase the master drives the address on the shared pins and pulses an address strobe, so that an external transparent latch can hold the address for the device. The strobe falls a short, fixed time before the address leaves the pins, which gives the latch hold time. Then chip select goes active and the shared pins carry one data byte in the most significant lane, together with an odd parity bit.

On the internal side a request gives a start address, a byte count of 1 to `MAX_BYTES` (sent as count minus one), write data, and the timing options. A request is taken with a valid/ready handshake. The master issues one access per byte at consecutive addresses and pulses `rsp_done` once the last access has finished. Read bytes show up on `rsp_rdata`. A read byte whose parity is wrong sets a sticky error flag.

All timing counts in ticks of `clk`. This clock runs at twice the platform rate, so one tick is half a platform period. One bus cycle is `TPB = 2*PLAT_PER_BUS` ticks.

Top module: `mab_bus_master`

## Requirements
- R1: While `rst_n` is low and after reset: `bus_ale`=0, `bus_cs_n`=1, `bus_ad_oe`=0, `req_ready`=1, `rsp_done`=0 and `par_err`=0.
- R2: A request for N bytes (`req_len`=N-1) produces exactly N strobe pulses and N chip-select pulses. Each strobe pulse comes before its own chip-select pulse, and the two are never active together.
- R3: The address phase lasts P = (`cfg_ale_cyc`+1+`cfg_addr_ext`)·TPB ticks. The strobe is high for the first P−H ticks of that phase, where H is the hold time.
- R4: With `cfg_ale_widen`=0 and `cfg_addr_ext`=0, H = 2 ticks (one platform period). The address stays driven (`bus_ad_oe`=1) and `bus_cs_n` stays high during those ticks.
- R5: `cfg_ale_widen`=1 makes the strobe one tick (half a platform period) longer and the hold one tick shorter.
- R6: `cfg_addr_ext`=1 adds TPB ticks to the address phase. Half of them lengthen the strobe and half lengthen the hold, so H grows by `PLAT_PER_BUS` ticks.
- R7: During the address phase `bus_ad_o[ADDR_W-1:0]` carries the byte address and `bus_a_lo` equals `bus_ad_o[A_LO_W-1:0]`. The byte address starts at `req_addr` and rises by 1 for each access.
- R8: In a write data phase, `bus_ad_o[BUS_W-1:BUS_W-8]` carries the byte and `bus_ad_oe`=1. `bus_dp_oe`=1 and `bus_dp_o` makes the 9 bits odd parity. Byte i is taken from `req_wdata[8i+7:8i]`.
- R9: In a read data phase `bus_ad_oe`=0 and `bus_dp_oe`=0. The byte on `bus_rd_byte` is sampled on the last tick of the phase and returned in `rsp_rdata[8i+7:8i]`.
- R10: A read byte for which `{bus_rd_byte, bus_dp_i}` has an even number of ones sets `par_err`. The flag then stays set until reset.
- R11: `bus_cs_n` is low for (`cfg_data_cyc`+1)·TPB ticks per byte. It is then high for at least TPB ticks before the next strobe.
- R12: `req_ready` is high only while idle. `rsp_done` is a single-tick pulse in the tick `req_ready` returns high after the last access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, twice the platform rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Master idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | IDX_W | Byte count minus one |
| req_wdata | input | 8·MAX_BYTES | Write bytes, byte i in lane i |
| cfg_ale_cyc | input | 2 | Strobe bus cycles minus one (1 to 4) |
| cfg_ale_widen | input | 1 | Widen strobe by one tick, cut hold by one tick |
| cfg_addr_ext | input | 1 | Extend the address phase by one bus cycle |
| cfg_data_cyc | input | 2 | Data-phase bus cycles minus one |
| rsp_done | output | 1 | One-tick pulse at the end of a request |
| rsp_rdata | output | 8·MAX_BYTES | Read bytes, byte i in lane i |
| par_err | output | 1 | Sticky read parity error |
| bus_ale | output | 1 | Address latch strobe |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_ad_o | output | BUS_W | Shared address/data pins, driven value |
| bus_ad_oe | output | 1 | Drive enable for the shared pins |
| bus_rd_byte | input | 8 | Upper data lane of the shared pins, read value |
| bus_a_lo | output | A_LO_W | Dedicated low-order address outputs |
| bus_dp_o | output | 1 | Data parity, driven value |
| bus_dp_oe | output | 1 | Drive enable for the parity pin |
| bus_dp_i | input | 1 | Data parity, read value |

## Verification
The first pattern is a full 32-byte write from 0x5420 with default timing. It shows whether the per-byte split, the address increment across the 0x543F end and the parity of changing bytes are right. Reads with the widened strobe, and a write with the extended address phase at the longest strobe and a long data phase, check that strobe length, hold length and chip-select length follow their separate formulas and are not swapped. A single-byte read checks the one-access boundary. A read with corrupted parity, followed by a clean write, separates a parity flag that is set and kept from one that is never set or that clears itself.

// File: rtl/mab_pkg.sv
package mab_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_DATA = 2'd2,
      PH_GAP  = 2'd3
   } phase_e;

   function automatic logic odd_par(input logic [7:0] b);
      return ~^b;
   endfunction
endpackage

// File: rtl/mab_timing.sv
module mab_timing #(
   parameter int PLAT_PER_BUS = 2,
   parameter int CNT_W        = 5
) (
   input  logic [1:0]       ale_cyc,
   input  logic             widen,
   input  logic             ext,
   input  logic [1:0]       data_cyc,
   output logic [CNT_W-1:0] addr_ticks,
   output logic [CNT_W-1:0] strobe_ticks,
   output logic [CNT_W-1:0] data_ticks
);
   localparam int TPB = 2 * PLAT_PER_BUS;

   int unsigned p_t, h_t, d_t;

   always_comb begin
      p_t = (32'(ale_cyc) + 32'd1 + 32'(ext)) * TPB;
      h_t = (widen ? 32'd1 : 32'd2) + (ext ? 32'(PLAT_PER_BUS) : 32'd0);
      d_t = (32'(data_cyc) + 32'd1) * TPB;
      addr_ticks   = CNT_W'(p_t);
      strobe_ticks = CNT_W'(p_t - h_t);
      data_ticks   = CNT_W'(d_t);
   end
endmodule

// File: rtl/mab_seq.sv
module mab_seq
   import mab_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 5,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [IDX_W-1:0]  start_last,
   input  logic [CNT_W-1:0]  addr_ticks,
   input  logic [CNT_W-1:0]  data_ticks,
   input  logic [CNT_W-1:0]  gap_ticks,
   output phase_e            phase,
   output logic [CNT_W-1:0]  tick,
   output logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              data_end,
   output logic              done
);
   logic [IDX_W-1:0] last_q;

   assign data_end = (phase == PH_DATA) && (tick == data_ticks - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         tick     <= '0;
         idx      <= '0;
         last_q   <= '0;
         cur_addr <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase    <= PH_ADDR;
                  tick     <= '0;
                  idx      <= '0;
                  last_q   <= start_last;
                  cur_addr <= start_addr;
               end
            end
            PH_ADDR: begin
               if (tick == addr_ticks - CNT_W'(1)) begin
                  phase <= PH_DATA;
                  tick  <= '0;
               end else begin
                  tick <= tick + CNT_W'(1);
               end
            end
            PH_DATA: begin
               if (data_end) begin
                  phase <= PH_GAP;
                  tick  <= '0;
               end else begin
                  tick <= tick + CNT_W'(1);
               end
            end
            PH_GAP: begin
               if (tick == gap_ticks - CNT_W'(1)) begin
                  tick <= '0;
                  if (idx == last_q) begin
                     phase <= PH_IDLE;
                     done  <= 1'b1;
                  end else begin
                     phase    <= PH_ADDR;
                     idx      <= idx + IDX_W'(1);
                     cur_addr <= cur_addr + ADDR_W'(1);
                  end
               end else begin
                  tick <= tick + CNT_W'(1);
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mab_pins.sv
module mab_pins
   import mab_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int BUS_W  = 32,
   parameter int A_LO_W = 5,
   parameter int CNT_W  = 5
) (
   input  phase_e            phase,
   input  logic [CNT_W-1:0]  tick,
   input  logic [CNT_W-1:0]  strobe_ticks,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [7:0]        wbyte,
   input  logic              write,
   input  logic [7:0]        rd_byte,
   input  logic              dp_i,
   output logic              ale,
   output logic              cs_n,
   output logic [BUS_W-1:0]  ad_o,
   output logic              ad_oe,
   output logic [A_LO_W-1:0] a_lo,
   output logic              dp_o,
   output logic              dp_oe,
   output logic              cap_perr
);
   logic [BUS_W-1:0] addr_word;
   logic [BUS_W-1:0] data_word;

   if (ADDR_W == BUS_W) begin : g_addr_full
      assign addr_word = cur_addr;
   end else begin : g_addr_pad
      assign addr_word = {{(BUS_W-ADDR_W){1'b0}}, cur_addr};
   end

   if (BUS_W == 8) begin : g_data_narrow
      assign data_word = wbyte;
   end else begin : g_data_top_lane
      assign data_word = {wbyte, {(BUS_W-8){1'b0}}};
   end

   logic in_addr, in_data;
   assign in_addr = (phase == PH_ADDR);
   assign in_data = (phase == PH_DATA);

   assign ale      = in_addr && (tick < strobe_ticks);
   assign cs_n     = !in_data;
   assign ad_oe    = in_addr || (in_data && write);
   assign ad_o     = in_addr ? addr_word : ((in_data && write) ? data_word : '0);
   assign a_lo     = cur_addr[A_LO_W-1:0];
   assign dp_oe    = in_data && write;
   assign dp_o     = dp_oe ? odd_par(wbyte) : 1'b0;
   assign cap_perr = ~(^{rd_byte, dp_i});
endmodule

// File: rtl/mab_bus_master.sv
module mab_bus_master
   import mab_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int BUS_W        = 32,
   parameter int A_LO_W       = 5,
   parameter int MAX_BYTES    = 32,
   parameter int PLAT_PER_BUS = 2,
   localparam int IDX_W       = $clog2(MAX_BYTES),
   localparam int DATA_W      = 8 * MAX_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [IDX_W-1:0]  req_len,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [1:0]        cfg_ale_cyc,
   input  logic              cfg_ale_widen,
   input  logic              cfg_addr_ext,
   input  logic [1:0]        cfg_data_cyc,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              par_err,
   output logic              bus_ale,
   output logic              bus_cs_n,
   output logic [BUS_W-1:0]  bus_ad_o,
   output logic              bus_ad_oe,
   input  logic [7:0]        bus_rd_byte,
   output logic [A_LO_W-1:0] bus_a_lo,
   output logic              bus_dp_o,
   output logic              bus_dp_oe,
   input  logic              bus_dp_i
);
   localparam int TPB   = 2 * PLAT_PER_BUS;
   localparam int CNT_W = $clog2(5 * TPB + 1);

   if (PLAT_PER_BUS < 2) begin : g_bad_ratio
      $error("PLAT_PER_BUS must be at least 2 so the strobe is never empty");
   end
   if (BUS_W < 8) begin : g_bad_bus
      $error("BUS_W must hold one byte lane");
   end
   if (ADDR_W > BUS_W) begin : g_bad_addr
      $error("ADDR_W must fit on the shared pins");
   end
   if (A_LO_W > ADDR_W || A_LO_W < 1) begin : g_bad_alo
      $error("A_LO_W must be 1..ADDR_W");
   end
   if (MAX_BYTES < 2) begin : g_bad_max
      $error("MAX_BYTES must be at least 2");
   end

   logic              write_q, widen_q, ext_q;
   logic [1:0]        ale_cyc_q, data_cyc_q;
   logic [DATA_W-1:0] wdata_q;
   logic              start;

   phase_e            phase;
   logic [CNT_W-1:0]  tick, addr_ticks, strobe_ticks, data_ticks;
   logic [IDX_W-1:0]  idx;
   logic [ADDR_W-1:0] cur_addr;
   logic              data_end, cap_perr;
   logic [7:0]        wbyte;

   assign req_ready = (phase == PH_IDLE);
   assign start     = req_valid && req_ready;
   assign wbyte     = wdata_q[int'(idx)*8 +: 8];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         write_q    <= 1'b0;
         widen_q    <= 1'b0;
         ext_q      <= 1'b0;
         ale_cyc_q  <= '0;
         data_cyc_q <= '0;
         wdata_q    <= '0;
      end else if (start) begin
         write_q    <= req_write;
         widen_q    <= cfg_ale_widen;
         ext_q      <= cfg_addr_ext;
         ale_cyc_q  <= cfg_ale_cyc;
         data_cyc_q <= cfg_data_cyc;
         wdata_q    <= req_wdata;
      end
   end

   mab_timing #(.PLAT_PER_BUS(PLAT_PER_BUS), .CNT_W(CNT_W)) u_timing (
      .ale_cyc      (ale_cyc_q),
      .widen        (widen_q),
      .ext          (ext_q),
      .data_cyc     (data_cyc_q),
      .addr_ticks   (addr_ticks),
      .strobe_ticks (strobe_ticks),
      .data_ticks   (data_ticks)
   );

   mab_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_addr (req_addr),
      .start_last (req_len),
      .addr_ticks (addr_ticks),
      .data_ticks (data_ticks),
      .gap_ticks  (CNT_W'(TPB)),
      .phase      (phase),
      .tick       (tick),
      .idx        (idx),
      .cur_addr   (cur_addr),
      .data_end   (data_end),
      .done       (rsp_done)
   );

   mab_pins #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .A_LO_W(A_LO_W), .CNT_W(CNT_W)) u_pins (
      .phase        (phase),
      .tick         (tick),
      .strobe_ticks (strobe_ticks),
      .cur_addr     (cur_addr),
      .wbyte        (wbyte),
      .write        (write_q),
      .rd_byte      (bus_rd_byte),
      .dp_i         (bus_dp_i),
      .ale          (bus_ale),
      .cs_n         (bus_cs_n),
      .ad_o         (bus_ad_o),
      .ad_oe        (bus_ad_oe),
      .a_lo         (bus_a_lo),
      .dp_o         (bus_dp_o),
      .dp_oe        (bus_dp_oe),
      .cap_perr     (cap_perr)
   );

   for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lane_q <= '0;
         else if (data_end && !write_q && idx == IDX_W'(g)) lane_q <= bus_rd_byte;
      end
      assign rsp_rdata[g*8 +: 8] = lane_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) par_err <= 1'b0;
      else if (data_end && !write_q && cap_perr) par_err <= 1'b1;
   end
endmodule

// File: rtl/mab_bus_chk.sv
module mab_bus_chk #(
   parameter int A_LO_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_done,
   input logic              par_err,
   input logic              bus_ale,
   input logic              bus_cs_n,
   input logic              bus_ad_oe,
   input logic [7:0]        ad_top,
   input logic [A_LO_W-1:0] ad_low,
   input logic [A_LO_W-1:0] bus_a_lo,
   input logic              bus_dp_o,
   input logic              bus_dp_oe
);
   a_r2_strobe_cs_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_ale && !bus_cs_n));

   a_r4_hold_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_ale) |-> (bus_ad_oe && bus_cs_n));

   a_r7_low_addr_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ale |-> (bus_a_lo == ad_low && bus_ad_oe));

   a_r8_write_odd_parity: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_cs_n && bus_ad_oe) |-> (bus_dp_oe && $countones({ad_top, bus_dp_o}) % 2 == 1));

   a_r10_parity_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      par_err |=> par_err);

   a_r11_gap_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_cs_n) |=> (bus_cs_n && !bus_ale));

   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (bus_cs_n && !bus_ale && !bus_ad_oe));

   a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);
endmodule

bind mab_bus_master mab_bus_chk #(.A_LO_W(A_LO_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rsp_done  (rsp_done),
   .par_err   (par_err),
   .bus_ale   (bus_ale),
   .bus_cs_n  (bus_cs_n),
   .bus_ad_oe (bus_ad_oe),
   .ad_top    (bus_ad_o[BUS_W-1 -: 8]),
   .ad_low    (bus_ad_o[A_LO_W-1:0]),
   .bus_a_lo  (bus_a_lo),
   .bus_dp_o  (bus_dp_o),
   .bus_dp_oe (bus_dp_oe)
);

// File: tb/sim_mab_bus_master.sv
module sim_mab_bus_master;
   localparam int PPB = 2;
   localparam int TPB = 2 * PPB;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic         req_valid = 0, req_write = 0;
   logic [31:0]  req_addr = 0;
   logic [4:0]   req_len = 0;
   logic [255:0] req_wdata = 0;
   logic [1:0]   cfg_ale_cyc = 0, cfg_data_cyc = 0;
   logic         cfg_ale_widen = 0, cfg_addr_ext = 0;
   logic         req_ready, rsp_done, par_err;
   logic [255:0] rsp_rdata;
   logic         bus_ale, bus_cs_n, bus_ad_oe, bus_dp_o, bus_dp_oe, bus_dp_i;
   logic [31:0]  bus_ad_o;
   logic [7:0]   bus_rd_byte;
   logic [4:0]   bus_a_lo;

   logic [31:0]  ext_latch = 0;
   bit           bad_par = 0;

   function automatic logic [7:0] rd_model(input logic [31:0] a);
      return a[7:0] ^ 8'hC3 ^ {a[11:8], a[15:12]};
   endfunction
   function automatic logic [7:0] wr_model(input logic [31:0] a, input int i);
      return 8'(a[7:0] + 8'(i * 37) + 8'h3C);
   endfunction

   assign bus_rd_byte = rd_model(ext_latch);
   assign bus_dp_i    = (~^rd_model(ext_latch)) ^ bad_par;

   mab_bus_master u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
      .cfg_ale_cyc(cfg_ale_cyc), .cfg_ale_widen(cfg_ale_widen), .cfg_addr_ext(cfg_addr_ext),
      .cfg_data_cyc(cfg_data_cyc), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .par_err(par_err),
      .bus_ale(bus_ale), .bus_cs_n(bus_cs_n), .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe),
      .bus_rd_byte(bus_rd_byte), .bus_a_lo(bus_a_lo), .bus_dp_o(bus_dp_o),
      .bus_dp_oe(bus_dp_oe), .bus_dp_i(bus_dp_i)
   );

   int checks = 0, errors = 0, cycles = 0;

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   typedef struct {
      logic [31:0] addr;
      bit          wr;
      logic [7:0]  data;
      int          s, h, d;
   } item_t;
   item_t q[$];

   // monitor / scoreboard
   item_t cur;
   bit    have = 0, seen_cs = 0, prev_ale = 0, prev_cs_n = 1, had_acc = 0;
   bit    addr_ok, hold_ok, data_ok;
   int    ale_cnt, hold_cnt, cs_cnt, gap_cnt = 0, acc_cnt = 0;

   always @(negedge clk) begin
      if (!rst_n) begin
         have = 0; had_acc = 0; prev_ale = 0; prev_cs_n = 1;
      end else begin
         if (bus_ale) ext_latch = bus_ad_o;
         if (bus_ale && !prev_ale) begin
            if (had_acc) chk(gap_cnt >= TPB, "R11 gap before strobe", gap_cnt, TPB);
            if (q.size() == 0) chk(0, "R2 unexpected strobe", 1, 0);
            else begin cur = q.pop_front(); have = 1; end
            ale_cnt = 0; hold_cnt = 0; cs_cnt = 0; seen_cs = 0;
            addr_ok = 1; hold_ok = 1; data_ok = 1;
         end
         if (bus_ale && have) begin
            ale_cnt++;
            addr_ok &= bus_ad_oe && bus_ad_o == cur.addr && bus_a_lo == cur.addr[4:0]
                       && bus_a_lo == bus_ad_o[4:0];
         end
         if (!bus_ale && bus_cs_n && have && !seen_cs) begin
            hold_cnt++;
            hold_ok &= bus_ad_oe && bus_ad_o == cur.addr;
         end
         if (!bus_cs_n && have) begin
            if (!seen_cs) begin
               chk(ale_cnt == cur.s, "R3 R5 R6 strobe ticks", ale_cnt, cur.s);
               chk(hold_cnt == cur.h, "R4 R5 R6 hold ticks", hold_cnt, cur.h);
               chk(addr_ok, "R7 address and low mirror", bus_ad_o, cur.addr);
               chk(hold_ok, "R4 address held after strobe", hold_ok, 1);
            end
            seen_cs = 1;
            cs_cnt++;
            if (cur.wr)
               data_ok &= bus_ad_oe && bus_ad_o[31:24] == cur.data && bus_dp_oe
                          && bus_dp_o == ~^cur.data;
            else
               data_ok &= !bus_ad_oe && !bus_dp_oe;
         end
         if (bus_cs_n && !prev_cs_n && have) begin
            chk(cs_cnt == cur.d, "R11 chip select ticks", cs_cnt, cur.d);
            chk(data_ok, cur.wr ? "R8 write lane and parity" : "R9 read bus released",
                bus_ad_o, cur.data);
            have = 0; had_acc = 1; gap_cnt = 0; acc_cnt++;
         end
         if (bus_cs_n && !bus_ale) gap_cnt++;
         prev_ale = bus_ale;
         prev_cs_n = bus_cs_n;
      end
   end

   task automatic run_xfer(input bit wr, input logic [31:0] a, input int n, input int ac,
                           input bit wd, input bit ex, input int dc, input bit badp);
      int p, h, s, d, base, t;
      logic [255:0] wv;
      item_t it;
      p = (ac + 1 + int'(ex)) * TPB;
      h = (wd ? 1 : 2) + (ex ? PPB : 0);
      s = p - h;
      d = (dc + 1) * TPB;
      wv = '0;
      for (int i = 0; i < n; i++) begin
         it.addr = a + 32'(i);
         it.wr = wr;
         it.data = wr ? wr_model(a, i) : 8'h00;
         it.s = s; it.h = h; it.d = d;
         wv[i*8 +: 8] = it.data;
         q.push_back(it);
      end
      base = acc_cnt;
      @(negedge clk);
      req_valid = 1; req_write = wr; req_addr = a; req_len = 5'(n - 1); req_wdata = wv;
      cfg_ale_cyc = 2'(ac); cfg_ale_widen = wd; cfg_addr_ext = ex; cfg_data_cyc = 2'(dc);
      bad_par = badp;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
      chk(!req_ready, "R12 ready low while busy", req_ready, 0);
      t = 0;
      while (!rsp_done && t < 20000) begin @(negedge clk); t++; end
      chk(rsp_done, "R12 done pulse seen", rsp_done, 1);
      chk(req_ready, "R12 ready with done", req_ready, 1);
      chk(acc_cnt - base == n, "R2 access count", acc_cnt - base, n);
      chk(q.size() == 0, "R2 all accesses seen", q.size(), 0);
      if (!wr)
         for (int i = 0; i < n; i++)
            chk(rsp_rdata[i*8 +: 8] == rd_model(a + 32'(i)), "R9 read byte",
                rsp_rdata[i*8 +: 8], rd_model(a + 32'(i)));
      @(negedge clk);
      chk(!rsp_done, "R12 done lasts one tick", rsp_done, 0);
      bad_par = 0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!bus_ale && bus_cs_n && !bus_ad_oe, "R1 bus idle in reset", {bus_ale, bus_cs_n, bus_ad_oe}, 3'b010);
      rst_n = 1;
      @(negedge clk);
      chk(req_ready && !rsp_done && !par_err, "R1 control idle after reset",
          {req_ready, rsp_done, par_err}, 3'b100);
      chk(!bus_ale && bus_cs_n, "R1 bus idle after reset", {bus_ale, bus_cs_n}, 2'b01);

      run_xfer(1, 32'h5420, 32, 0, 0, 0, 0, 0);      // R2 R7 R8 full line write
      run_xfer(0, 32'h1000_00FE, 4, 1, 1, 0, 1, 0);  // R5 R9 widened strobe read
      run_xfer(1, 32'hABCD_0010, 3, 3, 0, 1, 2, 0);  // R6 R11 extended address phase
      run_xfer(0, 32'h0000_7777, 1, 0, 0, 0, 0, 0);  // single byte read
      chk(!par_err, "R10 no error on clean reads", par_err, 0);
      run_xfer(0, 32'h0000_2200, 2, 0, 1, 1, 0, 1);  // corrupted parity
      chk(par_err, "R10 error set on bad parity", par_err, 1);
      run_xfer(1, 32'h0000_3300, 2, 2, 0, 0, 3, 0);
      chk(par_err, "R10 error stays set", par_err, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule